// File: doc/BRIEF.md
# HDLC Transmit FIFO with Underrun Abort

This block buffers packet bytes written by a host and sends them as HDLC frames on a one-bit serial data link. The host writes one byte per cycle into a byte-wide FIFO. It flags the final byte of each packet with an end-of-packet strobe that it asserts together with that write. The transmitter advances one bit each time the line-rate strobe `bit_en_i` is high. While it has nothing to send, it transmits idle flags. A packet begins at the next flag boundary. The transmitter inserts a zero after every run of five ones in the data, and it adds a closing flag after the marked last byte.

The FIFO may run dry after a byte that was not marked last. In that case the transmitter does not idle. It sends an abort of eight ones and then returns to idle flags. It also sets a sticky underrun flag, which the host clears with a status-read strobe. A live full indication tells the host when it must stop writing. A write that arrives while the FIFO is full is discarded.

Top module: `hdlc_tx_fifo`

## Requirements
- R1: After reset, `tx_bit_o` is 1, and both `full_o` and `underrun_o` are 0.
- R2: While the FIFO is empty and no packet is in progress, the line carries back-to-back flags 0x7E. Each flag is sent least significant bit first, which gives the bit order 0,1,1,1,1,1,1,0. `tx_bit_o` changes only on a clock edge where `bit_en_i` is high, and it advances by exactly one bit on each such edge.
- R3: Data bytes go out least significant bit first, so `wr_data_i[0]` is the first bit on the line and `wr_data_i[7]` is the last.
- R4: In packet data, a 0 is inserted after every five consecutive 1s. This also applies to a run that crosses a byte boundary and to a run at the end of the last byte, before the closing flag. Flags are never stuffed.
- R5: A write with `wr_last_i` high marks that byte as the last byte of its packet. A closing flag 0x7E follows it, so the receiver sees a frame whose bytes are exactly the bytes written for that packet.
- R6: `full_o` is high exactly while DEPTH bytes are stored. It is a live level, not a latched flag, and it falls once a byte is taken out.
- R7: A write while `full_o` is high is dropped. The stored bytes and their order are unchanged.
- R8: The FIFO may be empty when a byte that was not marked last finishes transmission. In that case the transmitter sends 0xFF, which is eight consecutive ones, then returns to idle flags, and it sets `underrun_o`. No frame is delivered for the aborted packet.
- R9: `underrun_o` stays high until a cycle with `stat_rd_i` high, and it reads 0 on the following cycle. If a new underrun is detected in the same cycle as the read, the flag stays set.
- R10: A packet starts only at the end of a complete flag. A byte written during an idle flag goes out after that flag, with no partial flag before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_data_i | input | 8 | Byte to queue; bit 0 is sent first |
| wr_last_i | input | 1 | Marks the written byte as the end of its packet |
| stat_rd_i | input | 1 | Status read strobe; clears the underrun flag |
| bit_en_i | input | 1 | Serial bit advance strobe |
| tx_bit_o | output | 1 | Serial line output |
| full_o | output | 1 | Live FIFO-full level |
| underrun_o | output | 1 | Sticky underrun flag |

## Verification
A wrong bit counter or a wrong stuffing run counter shows up on the line within one byte time. It appears as a misaligned flag, a run of six ones inside data, or a frame whose length is not a whole number of bytes. A fault in the FIFO pointers or the FIFO count appears at `full_o` in the cycle after the write that should have filled the FIFO. It also appears as wrong or reordered bytes in the next received frame. A lost end-of-packet mark shows at `underrun_o` and as an abort on the line once the FIFO drains, and that happens before the next flag boundary.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {MODE_FLAG, MODE_DATA, MODE_ABORT} tx_mode_e;
  localparam logic [7:0] FLAG_BYTE  = 8'h7E;
  localparam logic [7:0] ABORT_BYTE = 8'hFF;
  localparam int unsigned STUFF_RUN = 5;
endpackage

// File: rtl/hdlc_tx_fifo_buf.sv
module hdlc_tx_fifo_buf #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 9,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CW-1:0]    count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] ptr_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic       empty_i,
  input  logic [7:0] din_i,
  input  logic       last_i,
  output logic       pop_o,
  output logic       tx_bit_o,
  output logic       ur_set_o,
  output tx_mode_e   mode_o
);
  tx_mode_e   mode_q, mode_n;
  logic [7:0] sh_q, sh_n;
  logic [3:0] bcnt_q, bcnt_n;
  logic [2:0] ones_q, ones_n;
  logic       last_q, last_n, tx_q, tx_n, done;

  always_comb begin
    mode_n = mode_q; sh_n = sh_q; bcnt_n = bcnt_q; ones_n = ones_q;
    last_n = last_q; tx_n = tx_q; done = 1'b0; pop_o = 1'b0; ur_set_o = 1'b0;
    if (bit_en_i) begin
      if (mode_q == MODE_DATA && ones_q == 3'(STUFF_RUN)) begin
        tx_n   = 1'b0;
        ones_n = '0;
        done   = (bcnt_q == 4'd8);
      end else begin
        tx_n   = sh_q[0];
        sh_n   = {1'b0, sh_q[7:1]};
        bcnt_n = bcnt_q + 1'b1;
        if (mode_q == MODE_DATA) ones_n = sh_q[0] ? ones_q + 1'b1 : '0;
        // a run completing on the last bit delays the end for its stuff bit
        done = (bcnt_q == 4'd7) &&
               !(mode_q == MODE_DATA && sh_q[0] && ones_q == 3'(STUFF_RUN - 1));
      end
      if (done) begin
        bcnt_n = '0;
        if (mode_q == MODE_DATA && !last_q && empty_i) begin
          ur_set_o = 1'b1;
          mode_n   = MODE_ABORT;
          sh_n     = ABORT_BYTE;
          ones_n   = '0;
        end else if (mode_q != MODE_ABORT && !(mode_q == MODE_DATA && last_q) && !empty_i) begin
          pop_o  = 1'b1;
          mode_n = MODE_DATA;
          sh_n   = din_i;
          last_n = last_i;
        end else begin
          mode_n = MODE_FLAG;
          sh_n   = FLAG_BYTE;
          ones_n = '0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_FLAG;
      sh_q   <= FLAG_BYTE;
      bcnt_q <= '0;
      ones_q <= '0;
      last_q <= 1'b0;
      tx_q   <= 1'b1;
    end else begin
      mode_q <= mode_n;
      sh_q   <= sh_n;
      bcnt_q <= bcnt_n;
      ones_q <= ones_n;
      last_q <= last_n;
      tx_q   <= tx_n;
    end
  end

  assign tx_bit_o = tx_q;
  assign mode_o   = mode_q;
endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       wr_last_i,
  input  logic       stat_rd_i,
  input  logic       bit_en_i,
  output logic       tx_bit_o,
  output logic       full_o,
  output logic       underrun_o
);
  logic          pop, empty, ur_set, ur_q;
  logic [8:0]    head;
  logic [CW-1:0] count;
  tx_mode_e      mode;

  hdlc_tx_fifo_buf #(.DEPTH(DEPTH), .WIDTH(9)) u_buf (
    .clk_i, .rst_ni,
    .push_i (wr_en_i),
    .din_i  ({wr_last_i, wr_data_i}),
    .pop_i  (pop),
    .dout_o (head),
    .empty_o(empty),
    .full_o (full_o),
    .count_o(count)
  );

  hdlc_tx_framer u_framer (
    .clk_i, .rst_ni,
    .bit_en_i,
    .empty_i (empty),
    .din_i   (head[7:0]),
    .last_i  (head[8]),
    .pop_o   (pop),
    .tx_bit_o(tx_bit_o),
    .ur_set_o(ur_set),
    .mode_o  (mode)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ur_q <= 1'b0;
    else if (ur_set)    ur_q <= 1'b1;
    else if (stat_rd_i) ur_q <= 1'b0;
  end
  assign underrun_o = ur_q;
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk
  import hdlc_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          stat_rd_i,
  input logic          bit_en_i,
  input logic          tx_bit_o,
  input logic          full_o,
  input logic          underrun_o,
  input logic          pop_i,
  input logic          empty_i,
  input logic          ur_set_i,
  input logic [CW-1:0] count_i,
  input tx_mode_e      mode_i
);
  assert_tx_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(tx_bit_o));
  assert_full_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && pop_i) |=> !full_o);
  assert_no_pop_empty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_i);
  assert_drop_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o && !pop_i) |=> $stable(count_i));
  assert_ur_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> (mode_i == MODE_ABORT));
  assert_ur_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !ur_set_i) |=> !underrun_o);
  assert_ur_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underrun_o && !stat_rd_i) |=> underrun_o);
endmodule

bind hdlc_tx_fifo hdlc_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .stat_rd_i, .bit_en_i, .tx_bit_o, .full_o, .underrun_o,
  .pop_i(pop), .empty_i(empty), .ur_set_i(ur_set), .count_i(count), .mode_i(mode)
);

// File: tb/hdlc_tx_fifo_test.sv
module hdlc_tx_fifo_test;
  localparam int DEPTH = 4;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, wr_last_i = 0, stat_rd_i = 0, bit_en_i = 0;
  logic [7:0] wr_data_i = '0;
  logic tx_bit_o, full_o, underrun_o;
  int tests = 0, fails = 0;
  bit gate = 0;
  int phase = 0;

  // line receiver model
  bit   rxq[$];
  byte  frame[$];
  int   ones = 0, frames = 0, aborts = 0, flags = 0, stuffs = 0, bad = 0;

  always #4 clk_i = ~clk_i;

  hdlc_tx_fifo #(.DEPTH(DEPTH)) uut (.*);

  task automatic rx_bit(bit b);
    if (b) begin
      ones++;
      if (ones == 7) aborts++;
      if (ones >= 7) rxq.delete(); else rxq.push_back(1'b1);
    end else begin
      if (ones == 5) stuffs++;
      else if (ones == 6) begin
        int n = rxq.size() - 7;
        flags++;
        if (n > 0) begin
          if (n % 8 != 0) bad++;
          else begin
            frame.delete();
            for (int i = 0; i < n / 8; i++) begin
              byte v = 0;
              for (int k = 0; k < 8; k++) v[k] = rxq[8*i+k];
              frame.push_back(v);
            end
            frames++;
          end
        end
        rxq.delete();
      end else rxq.push_back(1'b0);
      ones = 0;
    end
  endtask

  always @(negedge clk_i) begin
    if (bit_en_i) rx_bit(tx_bit_o);
    phase = (phase + 1) % 4;
    bit_en_i = gate && (phase == 0);
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(byte d, bit last);
    wr_en_i = 1; wr_data_i = d; wr_last_i = last;
    @(negedge clk_i);
    wr_en_i = 0; wr_last_i = 0;
  endtask

  task automatic wait_frame(int target);
    for (int i = 0; i < 3000 && frames < target; i++) @(negedge clk_i);
  endtask

  task automatic check_frame(string req, byte exp[$]);
    check(req, frame.size(), exp.size());
    if (frame.size() == exp.size())
      foreach (exp[i]) check(req, int'(frame[i]) & 255, int'(exp[i]) & 255);
  endtask

  initial begin
    #1200000;
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    byte exp[$];
    int f0, a0, s0;
    repeat (3) @(negedge clk_i);
    check("R1 tx", tx_bit_o, 1);
    check("R1 full", full_o, 0);
    check("R1 underrun", underrun_o, 0);
    rst_ni = 1;
    @(negedge clk_i);
    check("R2 hold without bit_en", tx_bit_o, 1);
    gate = 1;
    repeat (4 * 8 * 8) @(negedge clk_i);
    check("R2 idle flags", (flags >= 7) ? 1 : 0, 1);
    check("R2 no frames", frames + aborts + bad, 0);

    // R3 R10: every single-byte packet
    for (int v = 0; v < 256; v++) begin
      f0 = frames;
      wr(byte'(v), 1'b1);
      wait_frame(f0 + 1);
      exp = {byte'(v)};
      check_frame("R3 R10 single byte", exp);
    end
    check("R10 no malformed", bad, 0);

    // R4 stuffing across boundary
    s0 = stuffs; f0 = frames;
    wr(8'hF8, 0); wr(8'h1F, 1);
    wait_frame(f0 + 1);
    exp = {8'hF8, 8'h1F};
    check_frame("R4 cross boundary", exp);
    check("R4 stuff count", stuffs - s0, 2);
    s0 = stuffs; f0 = frames;
    wr(8'hF8, 1);
    wait_frame(f0 + 1);
    check("R4 run before flag", stuffs - s0, 1);

    // R5 multi-byte packets
    f0 = frames;
    gate = 0;
    wr(8'h7E, 0); wr(8'hFF, 0); wr(8'h00, 0); wr(8'h3E, 1);
    gate = 1;
    wait_frame(f0 + 1);
    exp = {8'h7E, 8'hFF, 8'h00, 8'h3E};
    check_frame("R5 frame", exp);

    // R6 R7 full and dropped writes
    gate = 0;
    repeat (8) @(negedge clk_i);
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 not full", full_o, 0);
      wr(byte'(8'h10 + i), i == DEPTH - 1);
    end
    check("R6 full", full_o, 1);
    wr(8'hA5, 1); wr(8'h5A, 1);
    check("R7 still full", full_o, 1);
    f0 = frames;
    gate = 1;
    wait_frame(f0 + 1);
    check("R6 full released", full_o, 0);
    exp.delete();
    for (int i = 0; i < DEPTH; i++) exp.push_back(byte'(8'h10 + i));
    check_frame("R7 stored intact", exp);
    repeat (600) @(negedge clk_i);
    check("R7 dropped not sent", frames, f0 + 1);

    // R8 R9 underrun
    a0 = aborts; f0 = frames;
    gate = 0;
    wr(8'h55, 0); wr(8'hAA, 0);
    gate = 1;
    for (int i = 0; i < 3000 && aborts == a0; i++) @(negedge clk_i);
    check("R8 abort sent", aborts - a0, 1);
    @(negedge clk_i);
    check("R8 underrun set", underrun_o, 1);
    repeat (400) @(negedge clk_i);
    check("R8 no frame", frames, f0);
    check("R8 back to flags", ones < 7 ? 1 : 0, 1);
    check("R9 sticky", underrun_o, 1);
    stat_rd_i = 1;
    @(negedge clk_i);
    stat_rd_i = 0;
    check("R9 cleared", underrun_o, 0);
    f0 = frames;
    wr(8'hC3, 1);
    wait_frame(f0 + 1);
    exp = {8'hC3};
    check_frame("R9 recovery frame", exp);
    check("R9 stays clear", underrun_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule